// File: doc/BRIEF.md
# I2S Audio Transmit Channel

This block is the serial output half of an I2S audio port. Parallel audio samples are written into an eight-entry transmit FIFO. The block then shifts them out MSB first on a serial data line, framed by a bit clock and a word-select line. As bus master it divides the system clock to produce both framing lines. As slave it follows a bit clock and word select driven from outside, which it brings in through two-flop synchronisers.

Software picks the sample length (8, 16 or 32 bits) and stereo or mono framing. In master mode it also sets the bit-clock divider and the word-select half-period. Two fill-level thresholds drive an interrupt request and a DMA request, so that a producer can refill the FIFO before it runs dry. Three controls act independently:

- mute silences the data line while framing goes on;
- stop freezes shifting and draining;
- a soft reset clears the FIFO and the shifter.

An empty FIFO at the start of a word produces a zero sample and sets a sticky underflow flag.

Top module: `i2s_tx_chan`

## Requirements
- R1: After reset, sck_out, ws_out, sd_out and underflow are low, and irq and dma_req are high (the FIFO is empty).
- R2: The FIFO holds 8 samples. A write while it is full, with no read in the same cycle, is discarded. Only the first 8 of a burst of 10 writes are ever transmitted.
- R3: cfg_wsize selects the sample length: 0 is 8 bits, 1 is 16 bits, 2 or 3 is 32 bits. The sample is taken from the low bits of wr_data, and the upper bits are ignored. It is sent MSB first, and its MSB appears one bit clock after each word-select change. Data changes on the bit clock's falling edge. Bit slots beyond the sample length are zero.
- R4: In stereo mode (cfg_mono=0) every word-select half-period takes a new FIFO entry, so consecutive samples alternate channels. Word select low is the left channel.
- R5: In mono mode (cfg_mono=1) one FIFO entry is read per frame. It is sent in the left half (word select low) and repeated in the following right half.
- R6: As master (cfg_master=1), the bit clock period is 2*(cfg_div+1) system clocks. Word select toggles every cfg_half+1 bit-clock periods.
- R7: As slave (cfg_master=0), the block follows sck_in and ws_in and holds sck_out and ws_out low.
- R8: irq is high exactly when the FIFO level is at or below irq_thr.
- R9: dma_req is high exactly when the FIFO level is at or below dma_thr.
- R10: While cfg_mute is high, sd_out stays low, word select keeps toggling and the FIFO keeps draining.
- R11: While cfg_stop is high, no FIFO entry is consumed and sd_out stays low.
- R12: A soft_rst pulse empties the FIFO and clears the shifter and the underflow flag.
- R13: A word start that finds the FIFO empty sends a zero sample and sets underflow. The flag then stays high until an uf_clr pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of FIFO, shifter, framing and flag |
| cfg_master | input | 1 | 1 = generate bit clock and word select |
| cfg_mono | input | 1 | 1 = one sample per frame, repeated on both channels |
| cfg_wsize | input | 2 | Sample length code |
| cfg_div | input | DIV_W | Bit-clock half-period minus one, in system clocks |
| cfg_half | input | HALF_W | Word-select half-period minus one, in bit clocks |
| cfg_stop | input | 1 | Freeze shifting and draining |
| cfg_mute | input | 1 | Force serial data low |
| irq_thr | input | CNT_W | Interrupt fill-level threshold |
| dma_thr | input | CNT_W | DMA fill-level threshold |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | DW | Sample to enqueue, right-justified |
| uf_clr | input | 1 | Clear the underflow flag |
| sck_in | input | 1 | External bit clock (slave) |
| ws_in | input | 1 | External word select (slave) |
| sck_out | output | 1 | Generated bit clock (master) |
| ws_out | output | 1 | Generated word select (master) |
| sd_out | output | 1 | Serial audio data |
| irq | output | 1 | FIFO-low interrupt request |
| dma_req | output | 1 | FIFO-low DMA request |
| underflow | output | 1 | Sticky underflow flag |

## Verification
The bench decodes the serial stream the way a receiver would, and checks the position of each sample against word select. A one-bit misplacement of the MSB, or a truncated short word, therefore shows up as corrupted samples. Writes carry garbage above the sample length, which exposes a design that fails to discard those bits. A burst of ten writes into a stopped FIFO catches an overflow that overwrites entries. Repeating each mono sample on the right channel catches a design that reads twice per frame. Muting, stopping and underflow are each checked on the pins: muting must leave data silent while framing and draining continue; stopping must leave the fill level unchanged; underflow must send zeros and keep its flag set until it is cleared.

// File: rtl/i2s_tx_chan.sv
module i2s_tx_chan #(
  parameter int DEPTH  = 8,
  parameter int DW     = 32,
  parameter int HALF_W = 6,
  parameter int DIV_W  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cfg_master,
  input  logic              cfg_mono,
  input  logic [1:0]        cfg_wsize,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [HALF_W-1:0] cfg_half,
  input  logic              cfg_stop,
  input  logic              cfg_mute,
  input  logic [CNT_W-1:0]  irq_thr,
  input  logic [CNT_W-1:0]  dma_thr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              uf_clr,
  input  logic              sck_in,
  input  logic              ws_in,
  output logic              sck_out,
  output logic              ws_out,
  output logic              sd_out,
  output logic              irq,
  output logic              dma_req,
  output logic              underflow
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int SH_W  = $clog2(DW + 1);

  logic [DW-1:0]     mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [CNT_W-1:0]  cnt;
  logic [DIV_W-1:0]  dcnt;
  logic [HALF_W-1:0] hcnt;
  logic              sck_r, ws_q;
  logic [1:0]        sck_s, ws_s;
  logic              sck_d;
  logic              ws_smp, ws_last;
  logic [DW-1:0]     sh, hold;
  logic [SH_W-1:0]   rem;
  logic              sd_q, uf_q;

  logic tick, rise_evt, fall_evt, ws_line, frame_start, pop_req, pop, push;
  logic [SH_W-1:0] wlen;
  logic [DW-1:0]   word, aligned;

  assign tick        = cfg_master && (dcnt == cfg_div);
  assign rise_evt    = cfg_master ? (tick && !sck_r) : (sck_s[1] && !sck_d);
  assign fall_evt    = cfg_master ? (tick && sck_r)  : (!sck_s[1] && sck_d);
  assign ws_line     = cfg_master ? ws_q : ws_s[1];
  assign frame_start = fall_evt && (ws_smp != ws_last);
  assign pop_req     = frame_start && !cfg_stop && !(cfg_mono && ws_smp);
  assign pop         = pop_req && (cnt != '0);
  assign push        = wr_en && ((cnt != CNT_W'(DEPTH)) || pop);

  assign wlen = (cfg_wsize == 2'd0) ? SH_W'(8) :
                (cfg_wsize == 2'd1) ? SH_W'(16) : SH_W'(DW);
  assign word    = (cfg_mono && ws_smp) ? hold : ((cnt != '0) ? mem[rp] : '0);
  assign aligned = word << (SH_W'(DW) - wlen);

  assign sck_out   = cfg_master && sck_r;
  assign ws_out    = cfg_master && ws_q;
  assign sd_out    = sd_q && !cfg_mute;
  assign irq       = (cnt <= irq_thr);
  assign dma_req   = (cnt <= dma_thr);
  assign underflow = uf_q;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (soft_rst) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0; ws_s <= '0; sck_d <= 1'b0;
    end else begin
      sck_s <= {sck_s[0], sck_in};
      ws_s  <= {ws_s[0], ws_in};
      sck_d <= sck_s[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0; hcnt <= '0; sck_r <= 1'b0; ws_q <= 1'b0;
    end else if (soft_rst || !cfg_master) begin
      dcnt <= '0; hcnt <= '0; sck_r <= 1'b0; ws_q <= 1'b0;
    end else begin
      dcnt <= tick ? '0 : dcnt + 1'b1;
      if (tick) sck_r <= !sck_r;
      if (fall_evt) begin
        if (hcnt == cfg_half) begin
          hcnt <= '0;
          ws_q <= !ws_q;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_smp <= 1'b0; ws_last <= 1'b0; sh <= '0; hold <= '0;
      rem <= '0; sd_q <= 1'b0; uf_q <= 1'b0;
    end else if (soft_rst) begin
      ws_smp <= 1'b0; ws_last <= 1'b0; sh <= '0; hold <= '0;
      rem <= '0; sd_q <= 1'b0; uf_q <= 1'b0;
    end else begin
      if (rise_evt) ws_smp <= ws_line;
      if (fall_evt) begin
        ws_last <= ws_smp;
        if (cfg_stop) begin
          sd_q <= 1'b0;
          rem  <= '0;
        end else if (frame_start) begin
          sd_q <= aligned[DW-1];
          sh   <= aligned << 1;
          rem  <= wlen - 1'b1;
          if (!ws_smp) hold <= word;
        end else if (rem != '0) begin
          sd_q <= sh[DW-1];
          sh   <= sh << 1;
          rem  <= rem - 1'b1;
        end else begin
          sd_q <= 1'b0;
        end
      end
      if (pop_req && (cnt == '0)) uf_q <= 1'b1;
      else if (uf_clr) uf_q <= 1'b0;
    end
  end

  a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(DEPTH) && !pop && !soft_rst) |=> (cnt == CNT_W'(DEPTH)));

  a_r11_stop_no_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stop && !soft_rst) |=> (cnt >= $past(cnt)));

  a_r13_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !uf_clr && !soft_rst) |=> underflow);

  a_r13_empty_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && cnt == '0 && !soft_rst) |=> underflow);

  a_r5_mono_left_only: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cfg_mono) |-> !ws_line || !ws_smp);
endmodule

// File: tb/i2s_tx_chan_bench.sv
`timescale 1ns/1ps
module i2s_tx_chan_bench;
  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic cfg_master = 1'b1, cfg_mono = 1'b0, cfg_stop = 1'b1, cfg_mute = 1'b0;
  logic [1:0] cfg_wsize = 2'd1;
  logic [7:0] cfg_div = 8'd1;
  logic [5:0] cfg_half = 6'd15;
  logic [3:0] irq_thr = 4'd0, dma_thr = 4'd0;
  logic wr_en = 1'b0, uf_clr = 1'b0, sck_in, ws_in;
  logic [31:0] wr_data = '0;
  logic sck_out, ws_out, sd_out, irq, dma_req, underflow;

  i2s_tx_chan u_i2s_tx_chan (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_master(cfg_master),
    .cfg_mono(cfg_mono), .cfg_wsize(cfg_wsize), .cfg_div(cfg_div),
    .cfg_half(cfg_half), .cfg_stop(cfg_stop), .cfg_mute(cfg_mute),
    .irq_thr(irq_thr), .dma_thr(dma_thr), .wr_en(wr_en), .wr_data(wr_data),
    .uf_clr(uf_clr), .sck_in(sck_in), .ws_in(ws_in), .sck_out(sck_out),
    .ws_out(ws_out), .sd_out(sd_out), .irq(irq), .dma_req(dma_req),
    .underflow(underflow));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave-side clock source: bit clock half period 8 clk
  bit s_run = 1'b0;
  int s_half = 7;
  initial begin
    int sc = 0, fc = 0;
    sck_in = 1'b0; ws_in = 1'b0;
    forever begin
      @(posedge clk); #1;
      if (s_run) begin
        sc++;
        if (sc == 8) begin
          sc = 0;
          if (sck_in) begin
            sck_in = 1'b0;
            fc++;
            if (fc == s_half + 1) begin fc = 0; ws_in = ~ws_in; end
          end else sck_in = 1'b1;
        end
      end
    end
  end

  // receiver model
  logic [31:0] rx_w [0:255];
  bit          rx_c [0:255];
  int rx_n = 0, rx_size = 16, sd_hi = 0, ws_tog = 0;
  initial begin
    logic ps = 1'b0, pw = 1'b0, pend = 1'b0, coll = 1'b0, cch = 1'b0, lsck, lws, pwo = 1'b0;
    logic [31:0] acc = '0;
    int nb = 0;
    forever begin
      @(negedge clk);
      lsck = cfg_master ? sck_out : sck_in;
      lws  = cfg_master ? ws_out : ws_in;
      if (sd_out) sd_hi++;
      if (ws_out != pwo) ws_tog++;
      pwo = ws_out;
      if (lsck && !ps) begin
        if (pend) begin acc = {31'd0, sd_out}; nb = 1; coll = 1'b1; pend = 1'b0; cch = lws; end
        else if (coll) begin acc = {acc[30:0], sd_out}; nb++; end
        if (coll && nb == rx_size) begin
          if (rx_n < 256) begin rx_w[rx_n] = acc; rx_c[rx_n] = cch; rx_n++; end
          coll = 1'b0;
        end
        if (lws != pw) pend = 1'b1;
        pw = lws;
      end
      ps = lsck;
    end
  end

  task automatic cyc(int n); repeat (n) @(posedge clk); #1; endtask

  task automatic wr(logic [31:0] d);
    @(posedge clk); #1 wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic pulse_srst();
    @(posedge clk); #1 soft_rst = 1'b1;
    @(posedge clk); #1 soft_rst = 1'b0;
  endtask

  task automatic run_stream(int wsel, bit mono, bit master, int div, int extra, int nwr);
    logic [31:0] exp [0:9];
    logic [63:0] mask;
    int size, half, per, nexp, j, lvl, itv, dtv;
    size = (wsel == 0) ? 8 : (wsel == 1) ? 16 : 32;
    half = size - 1 + extra;
    mask = (64'd1 << size) - 64'd1;
    itv = $urandom_range(0, 8); dtv = $urandom_range(0, 8);
    @(posedge clk); #1;
    cfg_stop = 1'b1; cfg_wsize = wsel[1:0]; cfg_mono = mono; cfg_master = master;
    cfg_div = div[7:0]; cfg_half = half[5:0]; s_half = half; s_run = !master;
    irq_thr = itv[3:0]; dma_thr = dtv[3:0]; rx_size = size;
    cyc(4);
    pulse_srst();
    for (int i = 0; i < nwr; i++) begin
      logic [31:0] d;
      d = ($urandom & mask[31:0]) | (32'd1 << (size - 1));
      exp[i] = d;
      if (size < 32) d = d | ($urandom << size);
      wr(d);
      lvl = (i + 1 > 8) ? 8 : i + 1;
      chk("R8 irq level", {31'd0, irq}, {31'd0, lvl <= itv});
      chk("R9 dma level", {31'd0, dma_req}, {31'd0, lvl <= dtv});
    end
    cyc(8);
    j = rx_n;
    @(posedge clk); #1 cfg_stop = 1'b0;
    nexp = (nwr > 8) ? 8 : nwr;
    per = master ? 2 * (div + 1) : 16;
    cyc((nexp * (mono ? 2 : 1) + 6) * (half + 1) * per);
    while (j < rx_n && rx_w[j] == 32'd0) j++;
    chk("R4/R5 stream started", {31'd0, j < rx_n}, 32'd1);
    for (int i = 0; i < nexp * (mono ? 2 : 1); i++) begin
      if (j + i < rx_n) begin
        chk(mono ? "R5 mono sample" : "R3 R4 sample", rx_w[j + i], exp[mono ? i / 2 : i]);
        if (mono) chk("R5 channel", {31'd0, rx_c[j + i]}, {31'd0, i[0]});
        else if (i > 0) chk("R4 channel alternates", {31'd0, rx_c[j + i] ^ rx_c[j + i - 1]}, 32'd1);
      end else chk("R3 sample missing", 32'd0, 32'd1);
    end
    if (j + nexp * (mono ? 2 : 1) < rx_n)
      chk("R2 R13 zero after drain", rx_w[j + nexp * (mono ? 2 : 1)], 32'd0);
    chk("R13 underflow set", {31'd0, underflow}, 32'd1);
    if (!master) chk("R7 slave outputs low", {30'd0, sck_out, ws_out}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 reset outputs", {27'd0, sck_out, ws_out, sd_out, underflow, irq}, 32'd1);
    chk("R1 dma reset", {31'd0, dma_req}, 32'd1);

    // R6 master period and word-select half period
    @(posedge clk); #1 cfg_master = 1'b1; cfg_div = 8'd2; cfg_half = 6'd9; cfg_stop = 1'b1;
    begin
      logic p;
      int c, r;
      p = sck_out;
      forever begin @(negedge clk); if (sck_out && !p) break; p = sck_out; end
      c = 0; p = sck_out;
      forever begin @(negedge clk); c++; if (sck_out && !p) break; p = sck_out; end
      chk("R6 sck period", c, 32'd6);
      p = ws_out;
      forever begin @(negedge clk); if (ws_out != p) break; end
      p = ws_out; r = 0;
      begin
        logic q;
        q = sck_out;
        forever begin
          @(negedge clk);
          if (sck_out && !q) r++;
          q = sck_out;
          if (ws_out != p) break;
        end
      end
      chk("R6 ws half period", r, 32'd10);
    end

    run_stream(1, 1'b0, 1'b1, 1, 0, 8);
    run_stream(0, 1'b0, 1'b1, 0, 2, 10);   // R2 overflow burst
    run_stream(2, 1'b0, 1'b1, 1, 0, 6);
    run_stream(0, 1'b1, 1'b1, 1, 0, 5);
    run_stream(1, 1'b0, 1'b0, 0, 1, 4);    // R7 slave
    for (int t = 0; t < 4; t++)
      run_stream($urandom_range(0, 3), $urandom_range(0, 1), 1'b1, $urandom_range(0, 2),
                 $urandom_range(0, 3), $urandom_range(3, 10));

    // R13 clear while stopped
    @(posedge clk); #1 cfg_stop = 1'b1;
    cyc(4);
    @(posedge clk); #1 uf_clr = 1'b1;
    @(posedge clk); #1 uf_clr = 1'b0;
    chk("R13 underflow cleared", {31'd0, underflow}, 32'd0);

    // R11 stop keeps FIFO full level
    irq_thr = 4'd2;
    pulse_srst();
    wr(32'h55); wr(32'h66); wr(32'h77);
    cyc(200);
    chk("R11 no drain while stopped", {31'd0, irq}, 32'd0);
    chk("R11 data low while stopped", {31'd0, sd_out}, 32'd0);

    // R12 soft reset empties FIFO
    irq_thr = 4'd0;
    pulse_srst();
    chk("R12 FIFO empty after soft reset", {31'd0, irq}, 32'd1);
    chk("R12 underflow cleared", {31'd0, underflow}, 32'd0);

    // R10 mute: silent data, framing continues, FIFO drains
    begin
      int h0, t0;
      cfg_master = 1'b1; cfg_div = 8'd0; cfg_half = 6'd15; cfg_wsize = 2'd1; cfg_mono = 1'b0;
      wr(32'hFFFF); wr(32'hFFFF); wr(32'hFFFF);
      @(posedge clk); #1 cfg_mute = 1'b1; cfg_stop = 1'b0;
      h0 = sd_hi; t0 = ws_tog;
      cyc(1000);
      chk("R10 data silent", sd_hi - h0, 32'd0);
      chk("R10 framing runs", {31'd0, ws_tog - t0 > 4}, 32'd1);
      chk("R10 FIFO drained", {31'd0, irq}, 32'd1);
      @(posedge clk); #1 cfg_mute = 1'b0;
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule